// File: doc/BRIEF.md
# Command Phase Handshake Sequencer

This block steps a host-facing controller through its three phases: taking a command, letting an execution engine run it, and handing back result bytes. It drives the two handshake bits that the host polls before every access. The first is a request flag that says the controller can take or give a byte. The second is a direction flag that says which way that byte moves. The first byte written in the command phase is an opcode. Its low five bits select an entry in a fixed table, which gives the number of parameter bytes to collect and the number of result bytes to return. The parameter bytes are passed to the execution engine one at a time, in the order they arrive.

The request flag falls after every accepted host access and stays low for a fixed processing time. It rises again only when the controller wants the next byte. An opcode with no table entry skips execution and returns a single invalid-command status byte. Two software resets feed one shared core reset, which also clears the drive status and FIFO logic outside this block. The sticky reset bit is set by the hardware reset pin and stays set until software clears it. The other reset is a timed pulse that ends by itself. While the sticky bit is set, it overrides the timed pulse.

Top module: `cmd_phase_seq`

## Requirements
- R1: From the second rising edge after core_rst falls, rqm reads 1 and dio reads 0 (command phase, waiting for an opcode).
- R2: A host_wr is accepted only while rqm=1 and dio=0. A write at any other time changes no output: no param_vld pulse, no phase change, the same rd_data.
- R3: After an accepted write or read, rqm reads 0 for exactly PROC_LAT (default 2) cycles. If more bytes are needed in the same phase, rqm then returns to 1.
- R4: The parameter count is looked up from opcode bits 4:0: 0x03→2, 0x04→1, 0x05→8, 0x06→8, 0x07→1, 0x08→0, 0x0F→2, 0x13→3. Each parameter byte comes out on param_byte with a one-cycle param_vld pulse on the cycle after it is accepted, in arrival order. The opcode appears on cmd_op.
- R5: Once the last parameter byte has been processed (or the opcode itself, for a command with no parameters), exec_busy=1, rqm=0 and dio=0. These hold until exec_done.
- R6: Any opcode whose bits 4:0 are not in the R4 table goes straight to a result phase with rqm=1, dio=1 and rd_data=0x80. After that one byte is read, the sequencer returns to the command phase.
- R7: Result byte counts are 0x04→1, 0x05→7, 0x06→7, 0x08→2, and 0 for the rest. For each result byte, rqm=1, dio=1 and rd_data=exec_status. A host_rd takes the byte. After the last byte, the sequencer returns to the command phase. A command with no result bytes returns to the command phase on exec_done.
- R8: rst_n low sets the sticky hold bit. ctl_wr loads the bit from ctl_hold. core_rst is 1 on every cycle after the hold bit is set.
- R9: When the hold bit is clear, rate_wr with rate_rst=1 drives core_rst to 1 for exactly SELF_RST_CYC (default 4) cycles, starting on the next cycle. After that it releases by itself.
- R10: The hold bit takes precedence. While it is set, a self-clearing reset request is discarded. Setting the bit also cancels a timed pulse that is still running.
- R11: core_rst aborts any phase: rqm is 0 during the reset. Afterwards the sequencer takes a fresh opcode.
- R12: Opcode bits 7:5 do not affect the table lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset pin, synchronous, active low |
| ctl_wr | input | 1 | Write strobe for the sticky hold bit |
| ctl_hold | input | 1 | Value for the sticky hold bit (1 = hold the core in reset) |
| rate_wr | input | 1 | Write strobe for the rate-select register |
| rate_rst | input | 1 | Self-clearing reset request bit of the rate-select write |
| host_wr | input | 1 | Host write of a command or parameter byte |
| host_wdata | input | 8 | Byte written by the host |
| host_rd | input | 1 | Host read of the current result byte |
| exec_done | input | 1 | Execution engine has finished |
| exec_status | input | 8 | Result byte offered by the execution engine |
| rqm | output | 1 | Request-for-master: controller is ready for a byte transfer |
| dio | output | 1 | Direction: 1 = controller to host |
| rd_data | output | 8 | Current result byte (0 outside the result-wait state) |
| exec_busy | output | 1 | Execution phase is active |
| cmd_op | output | 8 | Latched opcode of the current command |
| param_vld | output | 1 | One-cycle strobe for a parameter byte |
| param_byte | output | 8 | Parameter byte handed to the execution engine |
| core_rst | output | 1 | Shared core reset (drive status, FIFO, sequencer) |

## Verification
The handshake is driven with several opcode types: one with no parameters and two result bytes, a short command with no results, a long transfer command with its upper opcode bits set, and an illegal opcode. Together these separate the paths for parameter counting, execution entry and result counting. Writes issued during the result and execution phases show whether the acceptance gate depends on both handshake bits. The reset tests start a timed reset in the middle of a command, set the hold bit during execution, and request a timed reset while the hold bit is set. These cases distinguish the exact pulse length, the abort behaviour, and the precedence of the sticky bit.

// File: rtl/cps_pkg.sv
// Package: shared types and the opcode shape table for the command phase
// sequencer. Assumes the opcode is indexed by its low five bits only.
package cps_pkg;

    localparam int IDX_W   = 5;
    localparam int CNT_W   = 4;

    typedef enum logic [2:0] {
        PH_RST,
        PH_CMD_WAIT,
        PH_CMD_PROC,
        PH_EXEC,
        PH_RES_WAIT,
        PH_RES_PROC
    } phase_t;

    typedef struct packed {
        logic             legal;
        logic [CNT_W-1:0] n_param;
        logic [CNT_W-1:0] n_result;
    } cmd_shape_t;

    // Maps an opcode index to its parameter and result byte counts.
    function automatic cmd_shape_t shape_of(input logic [IDX_W-1:0] idx);
        cmd_shape_t s;
        s = '{legal: 1'b1, n_param: '0, n_result: '0};
        case (idx)
            5'h03: s.n_param = 4'd2;
            5'h04: begin s.n_param = 4'd1; s.n_result = 4'd1; end
            5'h05: begin s.n_param = 4'd8; s.n_result = 4'd7; end
            5'h06: begin s.n_param = 4'd8; s.n_result = 4'd7; end
            5'h07: s.n_param = 4'd1;
            5'h08: s.n_result = 4'd2;
            5'h0F: s.n_param = 4'd2;
            5'h13: s.n_param = 4'd3;
            default: s.legal = 1'b0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/cps_opcode_lut.sv
// Module: opcode decoder. Turns the low opcode bits into the byte counts
// the sequencer needs. Pure combinational; assumes upper bits are ignored.
module cps_opcode_lut
    import cps_pkg::*;
(
    input  logic [IDX_W-1:0] op_idx,
    output cmd_shape_t       shape
);

    // Table lookup of the command shape.
    always_comb begin
        shape = shape_of(op_idx);
    end

endmodule

// File: rtl/cps_reset_ctl.sv
// Module: software reset combiner. Holds a sticky reset bit (set by the
// pin reset, cleared by software) and a timed self-clearing reset pulse.
// The sticky bit wins: while set, timed requests are dropped.
// Assumes synchronous active-low rst_n.
module cps_reset_ctl #(
    parameter int SELF_RST_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic ctl_hold,
    input  logic rate_wr,
    input  logic rate_rst,
    output logic core_rst
);

    localparam int SR_W = $clog2(SELF_RST_CYC + 1);

    logic            hold_q;
    logic [SR_W-1:0] pulse_cnt;
    logic            hold_set_req;
    logic            pulse_req;

    assign hold_set_req = ctl_wr && ctl_hold;
    assign pulse_req    = rate_wr && rate_rst;

    // Sticky hold bit: set on pin reset, loaded by software writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= 1'b1;
        else if (ctl_wr)
            hold_q <= ctl_hold;
    end

    // Timed pulse counter: loads on request, counts down, cancelled by hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse_cnt <= '0;
        else if (hold_q || hold_set_req)
            pulse_cnt <= '0;
        else if (pulse_req)
            pulse_cnt <= SR_W'(SELF_RST_CYC);
        else if (pulse_cnt != '0)
            pulse_cnt <= pulse_cnt - 1'b1;
    end

    // Shared core reset is the union of both sources.
    assign core_rst = hold_q || (pulse_cnt != '0);

    // R8
    hold_sets_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_set_req |=> core_rst);

    // R9
    pulse_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_cnt != '0 && !hold_q && !hold_set_req && !pulse_req)
        |=> pulse_cnt == $past(pulse_cnt) - 1'b1);

    // R10
    hold_precedence_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |=> pulse_cnt == '0);

endmodule

// File: rtl/cps_phase_fsm.sv
// Module: phase sequencer. Walks command, execution and result phases,
// counts parameter and result bytes and drives the two handshake flags.
// Assumes a shape lookup for the byte currently on host_wdata and a
// core reset that restarts it into the command phase.
module cps_phase_fsm
    import cps_pkg::*;
#(
    parameter int        PROC_LAT     = 2,
    parameter logic [7:0] INVALID_CODE = 8'h80
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       core_rst,
    input  logic       host_wr,
    input  logic [7:0] host_wdata,
    input  logic       host_rd,
    input  logic       exec_done,
    input  logic [7:0] exec_status,
    input  cmd_shape_t wr_shape,
    output logic       rqm,
    output logic       dio,
    output logic [7:0] rd_data,
    output logic       exec_busy,
    output logic [7:0] cmd_op,
    output logic       param_vld,
    output logic [7:0] param_byte
);

    localparam int PL_W = (PROC_LAT > 1) ? $clog2(PROC_LAT) : 1;

    phase_t           phase;
    logic [PL_W-1:0]  proc_cnt;
    logic [CNT_W-1:0] params_left;
    logic [CNT_W-1:0] res_left;
    logic             have_op;
    logic             bad_op;
    logic             wr_ok;
    logic             rd_ok;
    logic             srst;

    assign srst  = !rst_n || core_rst;
    assign wr_ok = (phase == PH_CMD_WAIT) && host_wr;
    assign rd_ok = (phase == PH_RES_WAIT) && host_rd;

    // Phase register and byte bookkeeping.
    always_ff @(posedge clk) begin
        if (srst) begin
            phase       <= PH_RST;
            proc_cnt    <= '0;
            params_left <= '0;
            res_left    <= '0;
            have_op     <= 1'b0;
            bad_op      <= 1'b0;
            cmd_op      <= '0;
        end else begin
            case (phase)
                PH_RST: phase <= PH_CMD_WAIT;
                PH_CMD_WAIT: if (wr_ok) begin
                    if (!have_op) begin
                        cmd_op      <= host_wdata;
                        have_op     <= 1'b1;
                        bad_op      <= !wr_shape.legal;
                        params_left <= wr_shape.n_param;
                        res_left    <= wr_shape.legal ? wr_shape.n_result : CNT_W'(1);
                    end else begin
                        params_left <= params_left - 1'b1;
                    end
                    proc_cnt <= PL_W'(PROC_LAT - 1);
                    phase    <= PH_CMD_PROC;
                end
                PH_CMD_PROC: begin
                    if (proc_cnt != '0)
                        proc_cnt <= proc_cnt - 1'b1;
                    else if (bad_op)
                        phase <= PH_RES_WAIT;
                    else if (params_left == '0)
                        phase <= PH_EXEC;
                    else
                        phase <= PH_CMD_WAIT;
                end
                PH_EXEC: if (exec_done) begin
                    if (res_left == '0) begin
                        phase   <= PH_CMD_WAIT;
                        have_op <= 1'b0;
                    end else begin
                        phase <= PH_RES_WAIT;
                    end
                end
                PH_RES_WAIT: if (rd_ok) begin
                    res_left <= res_left - 1'b1;
                    proc_cnt <= PL_W'(PROC_LAT - 1);
                    phase    <= PH_RES_PROC;
                end
                PH_RES_PROC: begin
                    if (proc_cnt != '0)
                        proc_cnt <= proc_cnt - 1'b1;
                    else if (res_left == '0) begin
                        phase   <= PH_CMD_WAIT;
                        have_op <= 1'b0;
                        bad_op  <= 1'b0;
                    end else
                        phase <= PH_RES_WAIT;
                end
                default: phase <= PH_RST;
            endcase
        end
    end

    // Parameter hand-off strobe to the execution engine.
    always_ff @(posedge clk) begin
        if (srst) begin
            param_vld  <= 1'b0;
            param_byte <= '0;
        end else begin
            param_vld <= wr_ok && have_op;
            if (wr_ok && have_op)
                param_byte <= host_wdata;
        end
    end

    // Handshake flags and result byte decode.
    always_comb begin
        rqm       = (phase == PH_CMD_WAIT) || (phase == PH_RES_WAIT);
        dio       = (phase == PH_RES_WAIT) || (phase == PH_RES_PROC);
        exec_busy = (phase == PH_EXEC);
        rd_data   = '0;
        if (phase == PH_RES_WAIT)
            rd_data = bad_op ? INVALID_CODE : exec_status;
    end

    // R3
    wr_drops_rqm_chk: assert property (@(posedge clk) disable iff (srst)
        (rqm && !dio && host_wr) |=> !rqm);

    // R3
    rd_drops_rqm_chk: assert property (@(posedge clk) disable iff (srst)
        (rqm && dio && host_rd) |=> (!rqm && dio));

    // R4
    param_strobe_chk: assert property (@(posedge clk) disable iff (srst)
        param_vld |-> $past(host_wr));

    // R5
    exec_hold_chk: assert property (@(posedge clk) disable iff (srst)
        (exec_busy && !exec_done) |=> (exec_busy && !rqm));

    // R11
    reset_blocks_rqm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |=> !rqm);

endmodule

// File: rtl/cmd_phase_seq.sv
// Module: top of the command phase handshake sequencer. Joins the reset
// combiner, the opcode table and the phase sequencer. Assumes a single
// clock and a synchronous active-low pin reset.
module cmd_phase_seq
    import cps_pkg::*;
#(
    parameter int         PROC_LAT     = 2,
    parameter int         SELF_RST_CYC = 4,
    parameter logic [7:0] INVALID_CODE = 8'h80
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic       ctl_hold,
    input  logic       rate_wr,
    input  logic       rate_rst,
    input  logic       host_wr,
    input  logic [7:0] host_wdata,
    input  logic       host_rd,
    input  logic       exec_done,
    input  logic [7:0] exec_status,
    output logic       rqm,
    output logic       dio,
    output logic [7:0] rd_data,
    output logic       exec_busy,
    output logic [7:0] cmd_op,
    output logic       param_vld,
    output logic [7:0] param_byte,
    output logic       core_rst
);

    cmd_shape_t wr_shape;

    cps_reset_ctl #(.SELF_RST_CYC(SELF_RST_CYC)) rst_ctl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (ctl_wr),
        .ctl_hold (ctl_hold),
        .rate_wr  (rate_wr),
        .rate_rst (rate_rst),
        .core_rst (core_rst)
    );

    cps_opcode_lut lut_i (
        .op_idx (host_wdata[IDX_W-1:0]),
        .shape  (wr_shape)
    );

    cps_phase_fsm #(.PROC_LAT(PROC_LAT), .INVALID_CODE(INVALID_CODE)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .core_rst    (core_rst),
        .host_wr     (host_wr),
        .host_wdata  (host_wdata),
        .host_rd     (host_rd),
        .exec_done   (exec_done),
        .exec_status (exec_status),
        .wr_shape    (wr_shape),
        .rqm         (rqm),
        .dio         (dio),
        .rd_data     (rd_data),
        .exec_busy   (exec_busy),
        .cmd_op      (cmd_op),
        .param_vld   (param_vld),
        .param_byte  (param_byte)
    );

endmodule

// File: tb/cmd_phase_seq_tb_top.sv
// Directed bench for the command phase handshake sequencer.
module cmd_phase_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0, ctl_hold = 1'b0;
    logic       rate_wr = 1'b0, rate_rst = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic       exec_done = 1'b0;
    logic [7:0] exec_status = '0;
    logic       rqm, dio, exec_busy, param_vld, core_rst;
    logic [7:0] rd_data, cmd_op, param_byte;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    cmd_phase_seq dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_hold(ctl_hold),
        .rate_wr(rate_wr), .rate_rst(rate_rst), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rd(host_rd), .exec_done(exec_done),
        .exec_status(exec_status), .rqm(rqm), .dio(dio), .rd_data(rd_data),
        .exec_busy(exec_busy), .cmd_op(cmd_op), .param_vld(param_vld),
        .param_byte(param_byte), .core_rst(core_rst)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_ready(input bit want_dio);
        for (int i = 0; i < 20; i++) begin
            if (rqm && dio == want_dio) return;
            tick();
        end
        chk(0, "R3 handshake timeout", {rqm, dio}, {1'b1, want_dio});
    endtask

    task automatic put_byte(input logic [7:0] b);
        wait_ready(1'b0);
        host_wr = 1'b1; host_wdata = b;
        tick();
        host_wr = 1'b0;
    endtask

    task automatic get_byte(input logic [7:0] exp, input string tag);
        wait_ready(1'b1);
        chk(rd_data == exp, tag, rd_data, exp);
        host_rd = 1'b1;
        tick();
        host_rd = 1'b0;
        chk(!rqm && dio, "R3 rqm low after read", {rqm, dio}, 2'b01);
    endtask

    task automatic finish_exec();
        for (int i = 0; i < 10 && !exec_busy; i++) tick();
        chk(exec_busy && !rqm && !dio, "R5 execution entered", {exec_busy, rqm, dio}, 3'b100);
        exec_done = 1'b1;
        tick();
        exec_done = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; tick(); tick();
        rst_n = 1'b1; tick();
        chk(core_rst && !rqm, "R8 reset pin sets hold", {core_rst, rqm}, 2'b10);
        repeat (3) tick();
        chk(core_rst, "R8 hold stays set", core_rst, 1);
        ctl_wr = 1'b1; ctl_hold = 1'b0; tick(); ctl_wr = 1'b0;
        chk(!core_rst && !rqm, "R1 rqm low just after release", {core_rst, rqm}, 2'b00);
        tick();
        chk(rqm && !dio, "R1 command phase after release", {rqm, dio}, 2'b10);
    endtask

    task automatic t_specify();
        put_byte(8'h03);
        chk(!rqm && !param_vld, "R3 rqm low after opcode", {rqm, param_vld}, 0);
        chk(cmd_op == 8'h03, "R4 opcode latched", cmd_op, 8'h03);
        tick();
        chk(!rqm, "R3 rqm low second cycle", rqm, 0);
        tick();
        chk(rqm && !dio, "R3 rqm back for parameter", {rqm, dio}, 2'b10);
        put_byte(8'hA1);
        chk(param_vld && param_byte == 8'hA1, "R4 first parameter", param_byte, 8'hA1);
        tick();
        chk(!param_vld, "R4 strobe one cycle", param_vld, 0);
        put_byte(8'hB2);
        chk(param_vld && param_byte == 8'hB2, "R4 second parameter", param_byte, 8'hB2);
        tick(); tick();
        chk(exec_busy && !rqm, "R5 exec after last parameter", {exec_busy, rqm}, 2'b10);
        finish_exec();
        chk(rqm && !dio && !exec_busy, "R7 no results back to command", {rqm, dio}, 2'b10);
    endtask

    task automatic t_read_cmd();
        int seen = 0;
        put_byte(8'hE6);
        chk(cmd_op == 8'hE6, "R12 opcode with upper bits latched", cmd_op, 8'hE6);
        for (int i = 0; i < 8; i++) begin
            put_byte(8'(8'h10 + i));
            if (param_vld && param_byte == 8'(8'h10 + i)) seen++;
            if (i < 7) begin
                tick(); tick();
                chk(rqm && !exec_busy, "R4 more parameters requested", {rqm, exec_busy}, 2'b10);
            end
        end
        chk(seen == 8, "R4 eight parameters in order", seen, 8);
        // R2: a write during execution must be ignored
        for (int i = 0; i < 10 && !exec_busy; i++) tick();
        host_wr = 1'b1; host_wdata = 8'h77; tick(); host_wr = 1'b0;
        chk(!param_vld && exec_busy, "R2 write ignored in execution", {param_vld, exec_busy}, 2'b01);
        exec_status = 8'h5A;
        finish_exec();
        for (int i = 0; i < 7; i++) get_byte(8'h5A, "R7 result byte data");
        wait_ready(1'b0);
        chk(rqm && !dio, "R7 back to command after seven results", {rqm, dio}, 2'b10);
    endtask

    task automatic t_sense();
        put_byte(8'h08);
        tick(); tick();
        chk(exec_busy, "R5 zero parameter command executes", exec_busy, 1);
        exec_status = 8'hC3;
        finish_exec();
        chk(rqm && dio, "R7 result phase entered", {rqm, dio}, 2'b11);
        get_byte(8'hC3, "R7 first result");
        get_byte(8'hC3, "R7 second result");
        tick(); tick();
        chk(rqm && !dio, "R7 command phase after two results", {rqm, dio}, 2'b10);
    endtask

    task automatic t_illegal();
        put_byte(8'h1F);
        tick(); tick();
        chk(rqm && dio && !exec_busy, "R6 illegal skips execution", {rqm, dio, exec_busy}, 3'b110);
        chk(rd_data == 8'h80, "R6 invalid status code", rd_data, 8'h80);
        host_wr = 1'b1; host_wdata = 8'h03; tick(); host_wr = 1'b0;
        chk(rqm && dio && rd_data == 8'h80 && !param_vld, "R2 write ignored in result", rd_data, 8'h80);
        get_byte(8'h80, "R6 invalid byte read");
        tick(); tick();
        chk(rqm && !dio, "R6 one byte then command", {rqm, dio}, 2'b10);
    endtask

    task automatic t_self_reset();
        put_byte(8'h13);
        put_byte(8'h01);
        rate_wr = 1'b1; rate_rst = 1'b1; tick(); rate_wr = 1'b0; rate_rst = 1'b0;
        for (int i = 0; i < 4; i++) begin
            chk(core_rst, "R9 timed reset active", core_rst, 1);
            tick();
            chk(!rqm, "R11 rqm low during reset", rqm, 0);
        end
        chk(!core_rst, "R9 timed reset releases", core_rst, 0);
        tick();
        chk(rqm && !dio, "R11 command phase after reset", {rqm, dio}, 2'b10);
        put_byte(8'h04);
        chk(cmd_op == 8'h04 && !param_vld, "R11 fresh opcode accepted", cmd_op, 8'h04);
        put_byte(8'h00);
        exec_status = 8'h21;
        finish_exec();
        get_byte(8'h21, "R7 single result");
    endtask

    task automatic t_precedence();
        ctl_wr = 1'b1; ctl_hold = 1'b1; tick(); ctl_wr = 1'b0;
        rate_wr = 1'b1; rate_rst = 1'b1; tick(); rate_wr = 1'b0; rate_rst = 1'b0;
        tick();
        ctl_wr = 1'b1; ctl_hold = 1'b0; tick(); ctl_wr = 1'b0;
        chk(!core_rst, "R10 timed request dropped under hold", core_rst, 0);
        tick();
        rate_wr = 1'b1; rate_rst = 1'b1; tick(); rate_wr = 1'b0; rate_rst = 1'b0;
        tick();
        ctl_wr = 1'b1; ctl_hold = 1'b1; tick(); ctl_wr = 1'b0;
        ctl_wr = 1'b1; ctl_hold = 1'b0; tick(); ctl_wr = 1'b0;
        chk(!core_rst, "R10 hold cancels running pulse", core_rst, 0);
        tick();
    endtask

    task automatic t_hold_abort();
        put_byte(8'h07);
        put_byte(8'h02);
        for (int i = 0; i < 10 && !exec_busy; i++) tick();
        ctl_wr = 1'b1; ctl_hold = 1'b1; tick(); ctl_wr = 1'b0;
        tick();
        chk(core_rst && !rqm && !exec_busy, "R11 hold aborts execution", {core_rst, rqm, exec_busy}, 3'b100);
        ctl_wr = 1'b1; ctl_hold = 1'b0; tick(); ctl_wr = 1'b0;
        tick();
        chk(rqm && !dio, "R1 command phase after hold cleared", {rqm, dio}, 2'b10);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_specify();
        t_read_cmd();
        t_sense();
        t_illegal();
        t_self_reset();
        t_precedence();
        t_hold_abort();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule